// File: doc/BRIEF.md
# AIS Alarm Qualifier with Change-of-State Interrupt

This block turns a per-frame alarm indication into a stable, declared alarm state. Each received DS3 frame comes with a strobe and a flag that says whether that frame carried the AIS pattern. The declared state changes only after a long run of frames that all disagree with it. The run length defaults to 63, and it applies to both setting and clearing the state.

Each flip of the declared state is a change-of-state event. When the event is enabled, it latches a status bit that clears when it is read, and the block pulls an active-low interrupt request line. Software reaches the block over a simple byte-wide register bus with one-cycle read latency. There are three registers. The interrupt-enable register is at 0x12. The interrupt-status register is at 0x13. A read-only live-state register is at 0x14, so a handler can learn which way the alarm moved. Both interrupt registers use the full 8-bit layout. Only the AIS position (bit 5) has a source in this block; the other seven positions are storage in the enable register and constant zero in the status register.

Top module: `ais_alarm_qual`

## Requirements
- R1: After reset the declared state is 0. It becomes 1 on the clock edge that samples the 63rd consecutive strobed frame with the AIS flag set. After 62 such frames it stays 0.
- R2: A declared state of 1 returns to 0 on the clock edge that samples the 63rd consecutive strobed frame with the AIS flag clear. After 62 such frames it stays 1.
- R3: A strobed frame that agrees with the current declared state restarts the run at zero. Cycles without a strobe neither advance the run nor break it. The run counter never reaches 63.
- R4: The enable register at address 0x12 holds all 8 bits, is readable and writable, and resets to 0x00. Bit 5 enables the AIS change-of-state interrupt.
- R5: Status bit 5 at address 0x13 is set when the declared state flips in either direction while enable bit 5 is 1. A flip while that enable bit is 0 sets nothing.
- R6: A read (reg_rd high for one cycle) places the register value on reg_rdata in the next cycle. A read of the status register returns its value from before the read and then clears the bits that were read.
- R7: irq_n goes low one cycle after any status bit and its enable bit are both 1, and is high otherwise. It resets to 1.
- R8: The present declared state appears on ais_active and as bit 0 of the read-only register at 0x14. The upper bits of that register read as 0.
- R9: If a state flip and a status read happen in the same cycle, the read returns the old value and status bit 5 stays set afterwards.
- R10: Clearing an enable bit leaves the latched status unchanged. Only irq_n follows the new enable value.
- R11: Status bits other than bit 5 always read 0. Writes to 0x13 and 0x14 have no effect. Unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking a received frame |
| frame_ais | input | 1 | AIS pattern present in the strobed frame |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq_n | output | 1 | Active-low interrupt request |
| ais_active | output | 1 | Declared AIS state |

## Verification
The bench sweeps every run length from 1 to 62, with gaps of idle cycles between frames, and checks that no run shorter than 63 declares the alarm. A design that counted cycles instead of strobes, or that kept its count across an agreeing frame, would declare too early. Exact 62/63 boundaries are checked in both directions, since an off-by-one counter would move the flip one frame late or early. A state flip is made to coincide with a status read; a design that lets the clear win would lose that interrupt. Disabling and re-enabling the interrupt shows whether the latched status survives, and a design that gates the status with the enable would drop the pending event.

// File: rtl/alm_qual_pkg.sv
package alm_qual_pkg;

   // Interrupt source layout shared by the enable and status registers.
   // Position 5 is the only one with a live source in this block.
   typedef struct packed {
      logic cp_parity;
      logic sig_loss;
      logic ais;
      logic idle_sig;
      logic far_fail;
      logic app_id;
      logic frame_loss;
      logic p_parity;
   } irq_vec_t;

   localparam int unsigned IRQ_VEC_W = $bits(irq_vec_t);
   localparam int unsigned AIS_POS   = 5;

   function automatic logic [IRQ_VEC_W-1:0] src_mask(input int unsigned pos);
      logic [IRQ_VEC_W-1:0] m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/alm_run_qualifier.sv
module alm_run_qualifier #(
   parameter int unsigned RUN_LEN = 63,
   localparam int unsigned CNT_W  = $clog2(RUN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             ind,
   output logic             state,
   output logic             flip,
   output logic [CNT_W-1:0] run_cnt
);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("alm_run_qualifier: RUN_LEN must be at least 2");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   logic             state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             disagree;
   logic             at_last;

   // A strobed frame disagreeing with the held state extends the run.
   assign disagree = stb && (ind != state_q);
   assign at_last  = (cnt_q == LAST);
   assign flip     = disagree && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         cnt_q   <= '0;
      end else if (stb) begin
         if (!disagree) begin
            cnt_q <= '0;
         end else if (at_last) begin
            state_q <= ~state_q;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign state   = state_q;
   assign run_cnt = cnt_q;

endmodule

// File: rtl/alm_enable_reg.sv
module alm_enable_reg #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ADDR   = 'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   if (ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("alm_enable_reg: ADDR does not fit in ADDR_W bits");
   end

   logic hit;
   assign hit = wr && (addr == ADDR_W'(ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (hit) begin
         q <= wdata;
      end
   end

endmodule

// File: rtl/alm_status_reg.sv
module alm_status_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt,
   input  logic [DATA_W-1:0] en,
   input  logic              clr,
   output logic [DATA_W-1:0] q
);

   // One sticky bit per source; a new event outranks a clearing read.
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic bit_q;
      logic set_now;

      assign set_now = evt[i] && en[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (set_now) begin
            bit_q <= 1'b1;
         end else if (clr) begin
            bit_q <= 1'b0;
         end
      end

      assign q[i] = bit_q;
   end

endmodule

// File: rtl/ais_alarm_qual.sv
module ais_alarm_qual #(
   parameter int unsigned RUN_LEN   = 63,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned EN_ADDR   = 'h12,
   parameter int unsigned ST_ADDR   = 'h13,
   parameter int unsigned LIVE_ADDR = 'h14,
   parameter int unsigned AIS_BIT   = alm_qual_pkg::AIS_POS,
   parameter bit          IRQ_REG   = 1'b1,
   localparam int unsigned CNT_W    = $clog2(RUN_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              frame_ais,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_n,
   output logic              ais_active
);

   if (AIS_BIT >= DATA_W) begin : g_bad_bit
      $error("ais_alarm_qual: AIS_BIT outside the register width");
   end
   if (EN_ADDR == ST_ADDR || EN_ADDR == LIVE_ADDR || ST_ADDR == LIVE_ADDR) begin : g_bad_map
      $error("ais_alarm_qual: register addresses must be distinct");
   end
   if (ST_ADDR >= (1 << ADDR_W) || LIVE_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("ais_alarm_qual: register address does not fit in ADDR_W bits");
   end

   logic              state;
   logic              flip;
   logic [CNT_W-1:0]  run_cnt;
   logic [DATA_W-1:0] en_q;
   logic [DATA_W-1:0] st_q;
   logic [DATA_W-1:0] evt;
   logic              rd_status;
   logic              rd_enable;
   logic              rd_live;
   logic              irq_any;

   alm_run_qualifier #(
      .RUN_LEN (RUN_LEN)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (frame_stb),
      .ind     (frame_ais),
      .state   (state),
      .flip    (flip),
      .run_cnt (run_cnt)
   );

   alm_enable_reg #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .ADDR   (EN_ADDR)
   ) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .q     (en_q)
   );

   // Event vector: only the AIS position has a source here.
   for (genvar i = 0; i < DATA_W; i++) begin : g_evt
      if (i == AIS_BIT) begin : g_src
         assign evt[i] = flip;
      end else begin : g_none
         assign evt[i] = 1'b0;
      end
   end

   assign rd_enable = reg_rd && (reg_addr == ADDR_W'(EN_ADDR));
   assign rd_status = reg_rd && (reg_addr == ADDR_W'(ST_ADDR));
   assign rd_live   = reg_rd && (reg_addr == ADDR_W'(LIVE_ADDR));

   alm_status_reg #(
      .DATA_W (DATA_W)
   ) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .en    (en_q),
      .clr   (rd_status),
      .q     (st_q)
   );

   // Registered read port; status returns its value before the clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         if (rd_enable) begin
            reg_rdata <= en_q;
         end else if (rd_status) begin
            reg_rdata <= st_q;
         end else if (rd_live) begin
            reg_rdata <= DATA_W'(state);
         end else begin
            reg_rdata <= '0;
         end
      end
   end

   assign irq_any = |(st_q & en_q);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q <= 1'b1;
         end else begin
            irq_q <= ~irq_any;
         end
      end
      assign irq_n = irq_q;
   end else begin : g_irq_comb
      assign irq_n = ~irq_any;
   end

   assign ais_active = state;

endmodule

// File: rtl/alm_qual_chk.sv
module alm_qual_chk #(
   parameter int unsigned RUN_LEN = 63,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned AIS_BIT = 5,
   parameter bit          IRQ_REG = 1'b1,
   parameter int unsigned CNT_W   = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb,
   input logic              frame_ais,
   input logic              ais_active,
   input logic              irq_n,
   input logic [DATA_W-1:0] en_q,
   input logic [DATA_W-1:0] st_q,
   input logic              flip,
   input logic              rd_clr,
   input logic [CNT_W-1:0]  run_cnt
);

   localparam logic [DATA_W-1:0] OTHER = ~(DATA_W'(1) << AIS_BIT);

   // R1: the state rises only on a strobed AIS frame ending a full run
   a_r1_rise_on_full_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ais_active) |-> $past(frame_stb && frame_ais && run_cnt == CNT_W'(RUN_LEN - 1)));

   // R2: the state falls only on a strobed clean frame ending a full run
   a_r2_fall_on_full_run: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ais_active) |-> $past(frame_stb && !frame_ais && run_cnt == CNT_W'(RUN_LEN - 1)));

   // R3: the run count stays below the run length
   a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt < CNT_W'(RUN_LEN));

   // R3: no strobe, no progress
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(run_cnt) && $stable(ais_active));

   // R5, R9: an enabled flip always leaves the status bit set
   a_r5_status_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (ais_active != $past(ais_active)) && $past(en_q[AIS_BIT]) |-> st_q[AIS_BIT]);

   // R6: a read with no coinciding event empties the status register
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_clr) && !$past(flip) |-> st_q == '0);

   // R11: positions without a source never latch
   a_r11_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q & OTHER) == '0);

   if (IRQ_REG) begin : g_irq_ff_chk
      // R7: request follows pending-and-enabled one cycle later
      a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
         (|(st_q & en_q)) |=> !irq_n);
      a_r7_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(st_q & en_q)) |=> irq_n);
   end else begin : g_irq_comb_chk
      a_r7_irq_now: assert property (@(posedge clk) disable iff (!rst_n)
         irq_n == !(|(st_q & en_q)));
   end

endmodule

bind ais_alarm_qual alm_qual_chk #(
   .RUN_LEN (RUN_LEN),
   .DATA_W  (DATA_W),
   .AIS_BIT (AIS_BIT),
   .IRQ_REG (IRQ_REG),
   .CNT_W   (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_stb  (frame_stb),
   .frame_ais  (frame_ais),
   .ais_active (ais_active),
   .irq_n      (irq_n),
   .en_q       (en_q),
   .st_q       (st_q),
   .flip       (flip),
   .rd_clr     (rd_status),
   .run_cnt    (run_cnt)
);

// File: tb/test_ais_alarm_qual.sv
`timescale 1ns/1ps
module test_ais_alarm_qual;

   localparam int RUN = 63;
   localparam logic [7:0] A_EN   = 8'h12;
   localparam logic [7:0] A_ST   = 8'h13;
   localparam logic [7:0] A_LIVE = 8'h14;
   localparam logic [7:0] M_AIS  = 8'h20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic       frame_ais = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_n;
   logic       ais_active;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   ais_alarm_qual i_ais_alarm_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .frame_ais  (frame_ais),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_n      (irq_n),
      .ais_active (ais_active)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic v);
      @(negedge clk);
      frame_stb = 1'b1;
      frame_ais = v;
      @(negedge clk);
      frame_stb = 1'b0;
      frame_ais = 1'b0;
   endtask

   task automatic frames(input logic v, input int n);
      for (int k = 0; k < n; k++) frame(v);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // Reset state
      chk("R7 reset irq_n", irq_n, 1);
      chk("R1 reset state", ais_active, 0);
      rd(A_EN, d);   chk("R4 enable reset", d, 8'h00);
      rd(A_ST, d);   chk("R6 status reset", d, 8'h00);
      rd(A_LIVE, d); chk("R8 live reset", d, 8'h00);

      // R4: every enable bit writable
      wr(A_EN, 8'hA5); rd(A_EN, d); chk("R4 enable A5", d, 8'hA5);
      wr(A_EN, 8'h5A); rd(A_EN, d); chk("R4 enable 5A", d, 8'h5A);
      wr(A_EN, 8'h00); rd(A_EN, d); chk("R4 enable 00", d, 8'h00);

      // R11: read-only and unmapped addresses
      wr(A_ST, 8'hFF);   rd(A_ST, d);   chk("R11 status write ignored", d, 8'h00);
      wr(A_LIVE, 8'hFF); rd(A_LIVE, d); chk("R11 live write ignored", d, 8'h00);
      chk("R11 state untouched by write", ais_active, 0);
      rd(8'h15, d); chk("R11 unmapped 15", d, 8'h00);
      rd(8'h00, d); chk("R11 unmapped 00", d, 8'h00);

      // R3 sweep: every short run, with idle gaps, then one agreeing frame
      for (int len = 1; len < RUN; len++) begin
         for (int k = 0; k < len; k++) begin
            frame(1'b1);
            idle((k + len) % 3);
         end
         chk("R3 short run not declared", ais_active, (len >= RUN) ? 1 : 0);
         frame(1'b0);
         chk("R3 agreeing frame keeps state", ais_active, 0);
      end

      // R1 boundary, interrupt disabled
      frames(1'b1, RUN - 1);
      chk("R1 62 frames", ais_active, 0);
      frame(1'b1);
      chk("R1 63 frames", ais_active, 1);
      rd(A_LIVE, d); chk("R8 live after declare", d, 8'h01);
      rd(A_ST, d);   chk("R5 disabled flip sets nothing", d, 8'h00);
      chk("R7 no request when disabled", irq_n, 1);

      // R2 boundary, interrupt enabled
      wr(A_EN, M_AIS);
      frames(1'b0, RUN - 1);
      chk("R2 62 clean frames", ais_active, 1);
      frame(1'b0);
      chk("R2 63 clean frames", ais_active, 0);
      chk("R7 irq one cycle after set", irq_n, 1);
      idle(1);
      chk("R7 irq low", irq_n, 0);
      rd(A_LIVE, d); chk("R8 live after clear", d, 8'h00);
      rd(A_ST, d);   chk("R5 clear transition latched", d, M_AIS);
      rd(A_ST, d);   chk("R6 second read empty", d, 8'h00);
      idle(1);
      chk("R7 irq released after read", irq_n, 1);

      // R3 restart with interrupt on
      frames(1'b1, 40);
      frame(1'b0);
      frames(1'b1, RUN - 1);
      chk("R3 restart after agreeing frame", ais_active, 0);
      frame(1'b1);
      chk("R3 declared after fresh run", ais_active, 1);
      rd(A_ST, d); chk("R5 declare transition latched", d, M_AIS);

      // R10: disabling keeps the latched status
      frames(1'b0, RUN);
      chk("R2 cleared again", ais_active, 0);
      idle(1);
      chk("R7 irq low before disable", irq_n, 0);
      wr(A_EN, 8'h00);
      idle(1);
      chk("R10 irq high while disabled", irq_n, 1);
      wr(A_EN, M_AIS);
      idle(1);
      chk("R10 irq back on re-enable", irq_n, 0);
      rd(A_ST, d); chk("R10 status survived disable", d, M_AIS);

      // R9: flip coincides with a status read
      frames(1'b1, RUN - 1);
      @(negedge clk);
      frame_stb = 1'b1; frame_ais = 1'b1;
      reg_rd = 1'b1; reg_addr = A_ST;
      @(negedge clk);
      frame_stb = 1'b0; frame_ais = 1'b0; reg_rd = 1'b0;
      chk("R9 read returns old value", reg_rdata, 8'h00);
      chk("R9 state flipped", ais_active, 1);
      rd(A_ST, d); chk("R9 event kept", d, M_AIS);

      // R11: other enables set, AIS disabled, flip sets nothing
      wr(A_EN, 8'hDF);
      frames(1'b0, RUN);
      chk("R2 cleared with AIS disabled", ais_active, 0);
      rd(A_ST, d); chk("R11 other bits stay zero", d, 8'h00);
      idle(1);
      chk("R7 no request from other enables", irq_n, 1);

      finish_run();
   end

endmodule